// File: doc/BRIEF.md
# Refreshing Four-Word DRAM Array Controller

This block models a small dynamic memory of four words, four bits each, together with the controller that shares every access period between one user operation and one automatic refresh. Each period is six clock cycles long. The first half of the period serves a user command: a precharge cycle, an access strobe and an output capture. The second half restores one word chosen by a rotating pointer: a read strobe and then a write strobe. The remaining cycle is the command-capture slot.

Storage is ideal. Reads use a precharged bit line that a stored 1 pulls low, and the sensed value is the inverse of that line. During a refresh write the write bit line is fed from the sensed value. During a user write it is fed from the registered user data. Commands enter through a valid/ready handshake. Ready is high only in the capture cycle, and the command is taken when valid and ready are both high. Read results leave as a one-cycle valid pulse with the data held afterwards. The result side has no ready input, because refresh timing cannot wait.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: Address value a selects word a. Bit 0 of `cmd_addr` is the low address bit, so 1 picks word 1 and 2 picks word 2.
- R2: The period phases are numbered 0 to 5 from reset. For an accepted read, `rwl[addr]` is high in phase 1 only. For an accepted write, `wwl[addr]` is high in phase 1 only.
- R3: In every period, `rwl[ptr]` is high in phase 3 and `wwl[ptr]` is high in phase 4, so the read strobe of the refresh comes before its write strobe.
- R4: The refresh pointer `ptr` is 0 in the first period after reset and advances by one, modulo 4, at the end of each period.
- R5: The refresh write-back restores the word it read, so stored data survives any number of refresh periods unchanged.
- R6: An accepted read drives the stored word onto `rd_data` with `rd_valid` high for exactly the cycle of phase 3 of the same period.
- R7: `rd_data` changes only in a cycle where `rd_valid` is high. Writes and idle periods leave it unchanged.
- R8: The first period after reset is a setup period: `cmd_ready` stays low throughout it, so no command can be accepted.
- R9: Two reads of the same word in a row return identical data.
- R10: Reset clears all words, `rd_data`, `rd_valid` and the refresh pointer to zero.
- R11: At most one word line of all eight is high in any cycle.
- R12: A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both high; `cmd_ready` is high only in phase 5. If `cmd_valid` is high in any other cycle, no user strobe results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command slot open (phase 5, not setup) |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| rwl | output | WORDS | Per-word read word-line strobes |
| wwl | output | WORDS | Per-word write word-line strobes |

## Verification
The bench attacks four corner cases.

- **Refresh correctness.** Long idle stretches let every word pass through many refresh cycles. A write-back that took the user bus instead of the sensed line would overwrite stored words with stale input data.
- **Back-to-back reads.** These expose a destructive read path or a bit line that is not precharged: the second read would return zeros or data from another word.
- **Setup period and early valid.** Commands are presented during the setup period and long before the capture slot. An eager handshake would fire strobes in the wrong phase.
- **Output hold across writes.** Writes are interleaved between reads. An output register that also loaded on writes would change `rd_data` without a valid pulse.

// File: rtl/dram_rf_pkg.sv
package dram_rf_pkg;
  typedef enum logic [2:0] {
    PH_PRE  = 3'd0,
    PH_USER = 3'd1,
    PH_OUT  = 3'd2,
    PH_RRD  = 3'd3,
    PH_RWR  = 3'd4,
    PH_CAP  = 3'd5
  } phase_e;
  localparam int NUM_PH = 6;
endpackage

// File: rtl/dram_rf_phase.sv
module dram_rf_phase
  import dram_rf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e ph,
  output logic   setup
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_PRE;
      setup <= 1'b1;
    end else begin
      ph <= (ph == PH_CAP) ? PH_PRE : phase_e'(ph + 3'd1);
      if (ph == PH_CAP) setup <= 1'b0;
    end
  end

  a_r4_period_wrap: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_CAP) |=> (ph == PH_PRE));
  a_r8_setup_one_period: assert property (@(posedge clk) disable iff (rst)
    $fell(setup) |-> ($past(ph) == PH_CAP));
endmodule

// File: rtl/dram_rf_wordline.sv
module dram_rf_wordline
  import dram_rf_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            ph,
  input  logic              act,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ref_ptr,
  output logic [WORDS-1:0]  rwl,
  output logic [WORDS-1:0]  wwl
);
  logic user_half, refresh_half, rw_pulse, ref_rd_pulse, ref_wr_pulse;

  assign user_half    = (ph == PH_PRE) || (ph == PH_USER) || (ph == PH_OUT);
  assign refresh_half = !user_half;
  assign rw_pulse     = (ph == PH_USER);
  assign ref_rd_pulse = (ph == PH_RRD);
  assign ref_wr_pulse = (ph == PH_RWR);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic word_sel, ref_sel;
    assign word_sel = act && (addr == ADDR_W'(i));
    assign ref_sel  = (ref_ptr == ADDR_W'(i));
    assign rwl[i] = (user_half && word_sel && !we && rw_pulse) ||
                    (refresh_half && ref_sel && ref_rd_pulse);
    assign wwl[i] = (user_half && word_sel && we && rw_pulse) ||
                    (refresh_half && ref_sel && ref_wr_pulse);
  end

  a_r11_one_read_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rwl));
  a_r11_read_write_apart: assert property (@(posedge clk) disable iff (rst)
    !((|rwl) && (|wwl)));
  a_r3_read_before_write: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RRD) |=> (wwl == $past(rwl)));
endmodule

// File: rtl/dram_rf_array.sv
module dram_rf_array
  import dram_rf_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            ph,
  input  logic [WORDS-1:0]  rwl,
  input  logic [WORDS-1:0]  wwl,
  input  logic [DATA_W-1:0] user_bits,
  output logic [DATA_W-1:0] sensed
);
  logic [DATA_W-1:0] cell_q [WORDS];
  logic [DATA_W-1:0] rbl_q;
  logic [DATA_W-1:0] wbl;
  logic [DATA_W-1:0] rd_word, wr_word;

  always_comb begin
    rd_word = '0;
    wr_word = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (rwl[i]) rd_word = rd_word | cell_q[i];
      if (wwl[i]) wr_word = wr_word | cell_q[i];
    end
  end

  assign sensed = ~rbl_q;
  assign wbl    = (ph == PH_RWR) ? sensed : user_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbl_q <= '1;
      for (int i = 0; i < WORDS; i++) cell_q[i] <= '0;
    end else begin
      if (ph == PH_PRE || ph == PH_OUT) rbl_q <= '1;
      else if (|rwl) rbl_q <= rbl_q & ~rd_word;
      for (int i = 0; i < WORDS; i++)
        if (wwl[i]) cell_q[i] <= wbl;
    end
  end

  a_r9_line_precharged: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_USER || ph == PH_RRD) |-> (rbl_q == '1));
  a_r5_writeback_matches: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RWR) |-> (sensed == wr_word));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_rf_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int DATA_W = 4,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [WORDS-1:0]  rwl,
  output logic [WORDS-1:0]  wwl
);
  phase_e            ph;
  logic              setup;
  logic              act_q, we_q;
  logic [ADDR_W-1:0] addr_q, ptr_q;
  logic [DATA_W-1:0] din_q, sensed;

  dram_rf_phase u_phase (.clk(clk), .rst(rst), .ph(ph), .setup(setup));

  dram_rf_wordline #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_wl (
    .clk(clk), .rst(rst), .ph(ph), .act(act_q), .we(we_q),
    .addr(addr_q), .ref_ptr(ptr_q), .rwl(rwl), .wwl(wwl));

  dram_rf_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst(rst), .ph(ph), .rwl(rwl), .wwl(wwl),
    .user_bits(din_q), .sensed(sensed));

  assign cmd_ready = (ph == PH_CAP) && !setup;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      din_q    <= '0;
      ptr_q    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (ph == PH_CAP) begin
        act_q  <= cmd_valid && cmd_ready;
        we_q   <= cmd_we;
        addr_q <= cmd_addr;
        din_q  <= cmd_wdata;
        ptr_q  <= ptr_q + 1'b1;
      end
      rd_valid <= 1'b0;
      if (ph == PH_OUT && act_q && !we_q) begin
        rd_data  <= sensed;
        rd_valid <= 1'b1;
      end
    end
  end

  a_r7_output_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));
  a_r4_pointer_step: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_CAP) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));
  a_r8_no_ready_in_setup: assert property (@(posedge clk) disable iff (rst)
    setup |-> !cmd_ready);
  a_r12_ready_only_slot: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |=> (ph == PH_PRE));
endmodule

// File: tb/sim_dram_refresh_ctrl.sv
module sim_dram_refresh_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_we = 1'b0;
  logic [1:0] cmd_addr = '0;
  logic [3:0] cmd_wdata = '0;
  logic       cmd_ready, rd_valid;
  logic [3:0] rd_data, rwl, wwl;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  dram_refresh_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rwl(rwl), .wwl(wwl));

  always #4 clk = ~clk;

  // behavioural reference
  int         ph_m, ptr_m, act_m, we_m, addr_m, setup_m;
  logic [3:0] din_m, dout_m;
  logic [3:0] mem_m [4];
  bit         vld_m;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ph_m = 0; ptr_m = 0; act_m = 0; we_m = 0; addr_m = 0; setup_m = 1;
      din_m = 0; dout_m = 0; vld_m = 0;
      for (int i = 0; i < 4; i++) mem_m[i] = 4'h0;
    end else begin
      if (ph_m == 1 && act_m != 0 && we_m != 0) mem_m[addr_m] = din_m;
      vld_m = 0;
      if (ph_m == 2 && act_m != 0 && we_m == 0) begin
        dout_m = mem_m[addr_m];
        vld_m  = 1;
      end
      if (ph_m == 5) begin
        act_m   = (cmd_valid && setup_m == 0) ? 1 : 0;
        we_m    = cmd_we ? 1 : 0;
        addr_m  = int'(cmd_addr);
        din_m   = cmd_wdata;
        ptr_m   = (ptr_m + 1) % 4;
        setup_m = 0;
      end
      ph_m = (ph_m + 1) % 6;
    end
  end

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %h expected %h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] er, ew;
      er = '0; ew = '0;
      if (ph_m == 1 && act_m != 0 && we_m == 0) er[addr_m] = 1'b1;
      if (ph_m == 1 && act_m != 0 && we_m != 0) ew[addr_m] = 1'b1;
      if (ph_m == 3) er[ptr_m] = 1'b1;
      if (ph_m == 4) ew[ptr_m] = 1'b1;
      check("R8/R12 cmd_ready", {3'b0, cmd_ready}, {3'b0, (ph_m == 5 && setup_m == 0)});
      check("R1/R2/R3/R4/R11 rwl", rwl, er);
      check("R1/R2/R3/R4/R11 wwl", wwl, ew);
      check("R5/R6/R7/R9 rd_data", rd_data, dout_m);
      check("R6/R7 rd_valid", {3'b0, rd_valid}, {3'b0, vld_m});
    end
  end

  // valid raised early on purpose, held until the slot passes
  task automatic issue(bit we, int addr, logic [3:0] data);
    cmd_valid = 1'b1; cmd_we = we; cmd_addr = 2'(addr); cmd_wdata = data;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_wdata = ~data;
  endtask

  task automatic idle(int periods);
    repeat (periods * 6) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R10: cleared outputs while in reset
    check("R10 rd_data", rd_data, 4'h0);
    check("R10 rd_valid", {3'b0, rd_valid}, 4'h0);
    rst = 1'b0;
  endtask

  initial begin
    cmd_valid = 1'b1; cmd_we = 1'b1; cmd_wdata = 4'hF;  // R8 setup: must be ignored
    do_reset();
    @(negedge clk);
    check("R8 ready low in setup", {3'b0, cmd_ready}, 4'h0);
    cmd_valid = 1'b0;
    for (int a = 0; a < 4; a++) issue(1'b1, a, 4'hF);
    for (int a = 0; a < 4; a++) begin issue(1'b0, a, 4'h0); issue(1'b0, a, 4'h0); end
    idle(10);  // R5: several refresh rounds
    for (int a = 0; a < 4; a++) issue(1'b0, a, 4'h0);
    for (int a = 0; a < 4; a++) issue(1'b1, a, 4'h0);
    for (int a = 0; a < 4; a++) begin issue(1'b0, a, 4'h0); issue(1'b0, a, 4'h0); end
    for (int a = 0; a < 4; a++) issue(1'b1, a, 4'(4'h5 ^ (a * 3)));
    idle(9);
    for (int a = 3; a >= 0; a--) begin issue(1'b0, a, 4'h0); issue(1'b1, (a + 1) % 4, 4'(a + 8)); end
    for (int a = 0; a < 4; a++) issue(1'b0, a, 4'h0);
    idle(3);
    do_reset();  // R10: stored words cleared
    idle(1);
    for (int a = 0; a < 4; a++) issue(1'b0, a, 4'h0);
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule